// File: doc/BRIEF.md
# Oversampled Framed Serial Receiver

This block receives 16-bit words sent over one serial wire, with no separate bit clock. Its clock runs at sixteen times the bit rate. When the line is idle it stays high. A frame is one low start bit, then the data bits with the most significant bit first, then one high stop bit. The receiver waits for the high-to-low transition that opens a frame. It checks that the start bit is still low at the middle of its cell, then reads every data bit at the middle of its cell.

When the stop bit reads high, the block loads the assembled word into its output register and raises an update strobe for one clock, so that a converter downstream can take the new code. When the stop bit reads low, the output register is left unchanged and an error pulse one clock wide is raised instead. Both counts are parameters: the cells have 16 clocks and the word has 16 bits by default.

Top module: `ovs_frame_rx`

## Requirements
- R1: While the asynchronous active-low reset is asserted, and after it is released, `rx_word` is 0 and `rx_update` and `rx_frame_err` are 0 until a frame completes.
- R2: Call E0 the first rising clock edge, with the receiver idle, at which `rx_line` is seen low when it was high at the previous edge. The start bit is sampled at E8. If it reads 1, the receiver returns to idle with no strobe, no error pulse and `rx_word` unchanged.
- R3: Data bits are sampled at E24, E40, and so on every 16 edges up to E264. The first sample is bit 15 of the word and the last is bit 0.
- R4: The stop bit is sampled at E280. If it reads 1, `rx_word` takes the received word at E280 and `rx_update` is 1 for exactly the one cycle that follows E280.
- R5: If the stop bit reads 0, `rx_frame_err` is 1 for exactly the one cycle that follows E280, `rx_update` stays 0 and `rx_word` keeps its previous value.
- R6: A new frame starts only on a high-to-low transition. A line held low after a framing error, or held low through reset release, starts no frame.
- R7: Line values at clock edges other than the centre samples have no effect on the received word.
- R8: A new start edge is accepted from E281 onward, so frames sent back to back with a stop cell of exactly 16 clocks are all received.
- R9: `rx_word` changes only at an edge that raises `rx_update`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversample clock, 16 times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial line, high when idle, synchronous to clk |
| rx_word | output | 16 | Last word received with a good stop bit |
| rx_update | output | 1 | One-clock strobe when rx_word is loaded |
| rx_frame_err | output | 1 | One-clock pulse when a stop bit reads 0 |

## Verification
The receiver is driven with words of mixed bits (A5C3), all zeros, all ones and single end bits (8001). A wrong bit order or an off-by-one in the sample positions shows up as a different value in `rx_word`. Some frames carry short inverted spikes away from the cell centres, which shows whether the block samples at the centre or somewhere else. The remaining cases each separate one control path from the normal one: a start pulse too short to reach mid-cell, a low stop bit followed by a held-low line, a line low through reset release, and frames sent with no idle gap between them. A behavioural model in the bench counts edges from E0 and compares all three outputs on every clock.

// File: rtl/ovs_rx_pkg.sv
package ovs_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/ovs_rx_edge.sv
module ovs_rx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic fall_o
);
  logic line_q;
  logic line_d;

  assign line_d = line_i;

  // Held low in reset so a line already low at release is not an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= line_d;
  end

  assign fall_o = line_q & ~line_i;
endmodule

// File: rtl/ovs_rx_timer.sv
module ovs_rx_timer #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic mid_o
);
  localparam int PW   = (OVS > 2) ? $clog2(OVS) : 1;
  localparam int HALF = OVS / 2;

  logic [PW-1:0] phase_q;
  logic [PW-1:0] phase_d;

  // Phase counts edges since E0; it wraps once per cell.
  always_comb begin
    phase_d = phase_q;
    if (clr_i)      phase_d = PW'(1);
    else if (run_i) phase_d = phase_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign mid_o = run_i && (phase_q == PW'(HALF));

  // R3: centre samples are one cell apart, never on adjacent edges
  p_mid_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mid_o |=> !mid_o);
endmodule

// File: rtl/ovs_rx_fsm.sv
module ovs_rx_fsm
  import ovs_rx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_i,
  input  logic mid_i,
  input  logic line_i,
  output logic run_o,
  output logic clr_o,
  output logic shift_o,
  output logic commit_o,
  output logic upd_o,
  output logic err_o
);
  localparam int BW = (DATA_W > 2) ? $clog2(DATA_W) : 1;

  rx_state_t     st_q, st_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          ferr;
  logic          upd_q, err_q;

  always_comb begin
    st_d     = st_q;
    bit_d    = bit_q;
    clr_o    = 1'b0;
    shift_o  = 1'b0;
    commit_o = 1'b0;
    ferr     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (fall_i) begin
          st_d  = ST_START;
          clr_o = 1'b1;
          bit_d = '0;
        end
      end
      ST_START: begin
        if (mid_i) st_d = line_i ? ST_IDLE : ST_DATA;
      end
      ST_DATA: begin
        if (mid_i) begin
          shift_o = 1'b1;
          if (bit_q == BW'(DATA_W - 1)) begin
            st_d  = ST_STOP;
            bit_d = '0;
          end else begin
            bit_d = bit_q + BW'(1);
          end
        end
      end
      ST_STOP: begin
        if (mid_i) begin
          commit_o = line_i;
          ferr     = ~line_i;
          st_d     = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign run_o = (st_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      bit_q <= '0;
      upd_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      bit_q <= bit_d;
      upd_q <= commit_o;
      err_q <= ferr;
    end
  end

  assign upd_o = upd_q;
  assign err_o = err_q;

  // R4: update strobe lasts one clock
  p_upd_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |=> !upd_q);
  // R5: framing error pulse lasts one clock
  p_err_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> !err_q);
  // R2: a start bit reading high at mid-cell aborts silently
  p_glitch_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_START && mid_i && line_i) |=> (st_q == ST_IDLE && !upd_q && !err_q));
endmodule

// File: rtl/ovs_rx_shift.sv
module ovs_rx_shift #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_i,
  input  logic              commit_i,
  input  logic              line_i,
  output logic [DATA_W-1:0] word_o
);
  logic [DATA_W-1:0] sreg_q, sreg_d;
  logic [DATA_W-1:0] word_q, word_d;

  always_comb begin
    sreg_d = sreg_q;
    word_d = word_q;
    if (shift_i)  sreg_d = {sreg_q[DATA_W-2:0], line_i};
    if (commit_i) word_d = sreg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      word_q <= '0;
    end else begin
      sreg_q <= sreg_d;
      word_q <= word_d;
    end
  end

  assign word_o = word_q;

  // R9: the output word moves only on a committed frame
  p_word_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(commit_i) |-> $stable(word_q));
endmodule

// File: rtl/ovs_frame_rx.sv
module ovs_frame_rx #(
  parameter int DATA_W = 16,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  output logic [DATA_W-1:0] rx_word,
  output logic              rx_update,
  output logic              rx_frame_err
);
  logic fall, mid, run, clr, shift_en, commit;

  ovs_rx_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (rx_line),
    .fall_o (fall)
  );

  ovs_rx_timer #(.OVS(OVS)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (clr),
    .run_i (run),
    .mid_o (mid)
  );

  ovs_rx_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .fall_i   (fall),
    .mid_i    (mid),
    .line_i   (rx_line),
    .run_o    (run),
    .clr_o    (clr),
    .shift_o  (shift_en),
    .commit_o (commit),
    .upd_o    (rx_update),
    .err_o    (rx_frame_err)
  );

  ovs_rx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_i  (shift_en),
    .commit_i (commit),
    .line_i   (rx_line),
    .word_o   (rx_word)
  );
endmodule

// File: tb/ovs_frame_rx_tb.sv
`timescale 1ns/1ps
module ovs_frame_rx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_line = 1'b0;
  logic [15:0] rx_word;
  logic        rx_update, rx_frame_err;

  int n_run = 0, n_fail = 0, n_upd = 0, n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ovs_frame_rx u_dut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line),
    .rx_word(rx_word), .rx_update(rx_update), .rx_frame_err(rx_frame_err)
  );

  // Behavioural reference: one edge count since E0
  bit          m_act, m_prev, exp_upd, exp_err;
  int          k;
  logic [15:0] acc, exp_word;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_prev = 0; k = 0; acc = '0;
      exp_word = '0; exp_upd = 0; exp_err = 0;
    end else begin
      exp_upd = 0; exp_err = 0;
      if (!m_act) begin
        if (m_prev && !rx_line) begin m_act = 1; k = 0; end
      end else begin
        k = k + 1;
        if (k == 8 && rx_line) m_act = 0;
        else if (k >= 24 && k <= 264 && ((k - 24) % 16) == 0) acc = {acc[14:0], rx_line};
        else if (k == 280) begin
          if (rx_line) begin exp_word = acc; exp_upd = 1; end
          else exp_err = 1;
          m_act = 0;
        end
      end
      m_prev = rx_line;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rx_update) n_upd++;
      if (rx_frame_err) n_err++;
      check(exp_upd ? "R4 strobe" : "R4 no strobe", {31'd0, rx_update}, {31'd0, exp_upd});
      check(exp_err ? "R5 error" : "R5 no error", {31'd0, rx_frame_err}, {31'd0, exp_err});
      check("R9 word", {16'd0, rx_word}, {16'd0, exp_word});
    end
  end

  task automatic idle(input int n, input bit v);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rx_line = v;
    end
  endtask

  task automatic send_frame(input logic [15:0] w, input bit stop, input bit glitch);
    for (int c = 0; c < 18; c++) begin
      bit v;
      v = (c == 0) ? 1'b0 : (c == 17) ? stop : w[16 - c];
      for (int p = 0; p < 16; p++) begin
        @(negedge clk);
        rx_line = (glitch && (p == 3 || p == 12)) ? ~v : v;
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int u0, e0;
    repeat (5) @(negedge clk);
    check("R1 reset word", {16'd0, rx_word}, 32'd0);
    check("R1 reset strobes", {30'd0, rx_update, rx_frame_err}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    idle(50, 1'b0);   // line low through reset release
    check("R6 no start after reset low", n_upd + n_err, 0);
    check("R1 word after release", {16'd0, rx_word}, 32'd0);
    idle(20, 1'b1);

    send_frame(16'hA5C3, 1'b1, 1'b0); idle(10, 1'b1);
    check("R3 word A5C3", {16'd0, rx_word}, 32'h0000A5C3);
    check("R4 one update", n_upd, 1);

    send_frame(16'h1234, 1'b1, 1'b1); idle(10, 1'b1);
    check("R7 glitched frame word", {16'd0, rx_word}, 32'h00001234);

    u0 = n_upd; e0 = n_err;
    send_frame(16'hFFFF, 1'b0, 1'b0);
    idle(60, 1'b0);
    check("R5 one error", n_err - e0, 1);
    check("R5 word kept", {16'd0, rx_word}, 32'h00001234);
    check("R6 no frame while held low", (n_upd - u0) + (n_err - e0 - 1), 0);
    idle(20, 1'b1);
    send_frame(16'h8001, 1'b1, 1'b0); idle(10, 1'b1);
    check("R6 rearmed after high", {16'd0, rx_word}, 32'h00008001);

    u0 = n_upd; e0 = n_err;
    idle(4, 1'b0); idle(40, 1'b1);
    check("R2 short start ignored", (n_upd - u0) + (n_err - e0), 0);
    check("R2 word kept", {16'd0, rx_word}, 32'h00008001);

    u0 = n_upd;
    send_frame(16'h0F0F, 1'b1, 1'b0);
    send_frame(16'hF0F0, 1'b1, 1'b0);
    send_frame(16'h0000, 1'b1, 1'b0); idle(10, 1'b1);
    check("R8 back to back count", n_upd - u0, 3);
    check("R3 zero word", {16'd0, rx_word}, 32'h00000000);

    send_frame(16'hFFFF, 1'b1, 1'b1); idle(10, 1'b1);
    check("R3 ones word", {16'd0, rx_word}, 32'h0000FFFF);
    finish_run();
  end
endmodule